// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block sits beside a processor's data cache in a commit-based hardware transactional memory. Every cache line carries, next to its tag and valid bit, one speculative read bit and one speculative write bit per word. Transactional loads mark words as read. Transactional stores mark words as written, update the line data, and append the line address to an ordered queue the first time that line is written in the transaction.

While the transaction runs, commit addresses broadcast by other processors arrive on a snoop port that has its own tag lookup, so it never competes with processor accesses. A snooped word that hits a locally read word raises a one-cycle violation. At the same clock edge all speculative state is dropped, and the processor then rolls back and re-executes.

When the processor holds commit permission and requests a commit, the block walks the queued lines oldest first. It puts every written word, with its address and data, on the commit bus, then pulses a done strobe and clears all speculative state. If the queue is full and a store touches a line that is not yet queued, an overflow flag is raised. That store stalls until commit permission is held, and from then on such stores are written straight through to the commit bus.

Top module: `trk_conflict_tracker`

## Requirements
- R1: After reset, violation, commitValid, commitDone and overflow are low and cpuReady is high while no access is presented.
- R2: An accepted load sets only the read bit of the addressed word. A snoop to another word of the same line, or to the same line index with a different tag, raises no violation.
- R3: An accepted store sets the write bit of the addressed word. A snoop to a word that has been written but not read raises no violation.
- R4: A snoop in the idle state whose address matches a valid line's tag at a word whose read bit is set makes violation high in the next cycle, for exactly one cycle.
- R5: A violation clears every read and write bit and empties the line queue at the same clock edge. Later snoops to previously read words raise nothing, and a following commit sends no words.
- R6: After commitStart is sampled with tokenHeld high, the block scans queued lines oldest first, spending WORDS cycles per line with words in ascending order. In each cycle whose word has its write bit set, it drives commitValid, commitAddr = {line address, word index} and commitData = the most recent stored value.
- R7: commitDone is high for exactly one cycle, in the first drain cycle in which the queue is empty, and all speculative state is clear afterwards.
- R8: Repeated stores to a line already queued add no queue entry. The line is broadcast once and uses one queue slot.
- R9: When the queue holds FIFO_DEPTH lines and a store targets a line not in the queue, overflow is high. cpuReady is low for that store unless tokenHeld is high.
- R10: Such an overflowing store with tokenHeld high is accepted and appears on the commit bus in the same cycle with its own address and data. It is not tracked, so it is not sent again at commit.
- R11: While draining, cpuReady is low and snoop addresses raise no violation.
- R12: A snoop and a processor load presented in the same cycle are both handled. A load to the snooped word is marked read only after that snoop's lookup, so that snoop does not hit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor access present |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address {tag, index, word} |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Access accepted this cycle |
| overflow | output | 1 | Store needs a queue slot that is not free |
| tokenHeld | input | 1 | This processor holds commit permission |
| commitStart | input | 1 | Begin draining the write set |
| snoopValid | input | 1 | Remote commit address present |
| snoopAddr | input | ADDR_W | Remote commit word address |
| violation | output | 1 | Conflict detected, transaction must restart |
| commitValid | output | 1 | Commit bus beat valid |
| commitAddr | output | ADDR_W | Commit bus word address |
| commitData | output | DATA_W | Commit bus data |
| commitDone | output | 1 | Commit finished, state cleared |

## Verification
The bench builds the block with a four-entry line queue, 16 lines of 8 words and a 12-bit address. The shallow queue makes the full-queue stall and the write-through path reachable after only four stores. The 12-bit address leaves room for a tag bit above the index, so aliasing snoops on a same-index line with a different tag can be exercised. A behavioural model keeps read and write sets as word-keyed maps and the queue as an ordered list, and predicts every output on every cycle, including the exact drain cycle of each beat.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic {
    TRK_IDLE  = 1'b0,
    TRK_DRAIN = 1'b1
  } trkState_e;

  // Strobes from the control to the datapath, one per state update.
  typedef struct packed {
    logic setRead;
    logic setWrite;
    logic writeData;
    logic push;
    logic pop;
    logic clearAll;
  } trkStrobe_t;

endpackage

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int WORDS      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  trkStrobe_t                              stb,
  input  logic [ADDR_W-1:0]                       cpuAddr,
  input  logic [DATA_W-1:0]                       cpuWdata,
  input  logic                                    snoopValid,
  input  logic [ADDR_W-1:0]                       snoopAddr,
  input  logic [$clog2(WORDS)-1:0]                scanWord,
  output logic                                    snoopHit,
  output logic                                    lineQueued,
  output logic                                    fifoFull,
  output logic                                    fifoEmpty,
  output logic [ADDR_W-$clog2(WORDS)-1:0]         headLine,
  output logic                                    headWritten,
  output logic [DATA_W-1:0]                       headData
);

  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - WSEL_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  // Per-line state
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [WORDS-1:0]  rdBits   [LINES];
  logic [WORDS-1:0]  wrBits   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES][WORDS];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  queuedArr;

  // Line-address queue
  logic [LINE_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;

  // Address fields, processor side
  logic [IDX_W-1:0]  cpuIdx;
  logic [WSEL_W-1:0] cpuWord;
  logic [TAG_W-1:0]  cpuTag;
  logic [LINE_W-1:0] cpuLine;
  assign cpuLine = cpuAddr[ADDR_W-1:WSEL_W];
  assign cpuIdx  = cpuLine[IDX_W-1:0];
  assign cpuTag  = cpuLine[LINE_W-1:IDX_W];
  assign cpuWord = cpuAddr[WSEL_W-1:0];

  // Address fields, snoop side (second tag port)
  logic [LINE_W-1:0] snpLine;
  logic [IDX_W-1:0]  snpIdx;
  logic [WSEL_W-1:0] snpWord;
  logic [TAG_W-1:0]  snpTag;
  assign snpLine = snoopAddr[ADDR_W-1:WSEL_W];
  assign snpIdx  = snpLine[IDX_W-1:0];
  assign snpTag  = snpLine[LINE_W-1:IDX_W];
  assign snpWord = snoopAddr[WSEL_W-1:0];

  assign snoopHit = snoopValid && validArr[snpIdx] &&
                    (tagArr[snpIdx] == snpTag) && rdBits[snpIdx][snpWord];
  assign lineQueued = queuedArr[cpuIdx];

  logic [IDX_W-1:0] headIdx;
  assign headLine    = fifoMem[rdPtr];
  assign headIdx     = headLine[IDX_W-1:0];
  assign headWritten = wrBits[headIdx][scanWord];
  assign headData    = dataArr[headIdx][scanWord];

  assign fifoFull  = (count == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (count == '0);

  // Speculative bits: a clear overrides every set in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr  <= '0;
      queuedArr <= '0;
      for (int i = 0; i < LINES; i++) begin
        rdBits[i] <= '0;
        wrBits[i] <= '0;
      end
    end else if (stb.clearAll) begin
      queuedArr <= '0;
      for (int i = 0; i < LINES; i++) begin
        rdBits[i] <= '0;
        wrBits[i] <= '0;
      end
    end else begin
      if (stb.setRead || stb.writeData) validArr[cpuIdx] <= 1'b1;
      if (stb.setRead)  rdBits[cpuIdx][cpuWord] <= 1'b1;
      if (stb.setWrite) wrBits[cpuIdx][cpuWord] <= 1'b1;
      if (stb.push)     queuedArr[cpuIdx]       <= 1'b1;
    end
  end

  // Tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (stb.setRead || stb.writeData) tagArr[cpuIdx] <= cpuTag;
    if (stb.writeData) dataArr[cpuIdx][cpuWord] <= cpuWdata;
    if (stb.push) fifoMem[wrPtr] <= cpuLine;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (stb.clearAll) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      if (stb.push && !stb.pop)      count <= count + CNT_W'(1);
      else if (stb.pop && !stb.push) count <= count - CNT_W'(1);
    end
  end

endmodule

// File: rtl/trk_control.sv
module trk_control
  import trk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuValid,
  input  logic                            cpuWrite,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  input  logic                            tokenHeld,
  input  logic                            commitStart,
  input  logic                            snoopHit,
  input  logic                            lineQueued,
  input  logic                            fifoFull,
  input  logic                            fifoEmpty,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] headLine,
  input  logic                            headWritten,
  input  logic [DATA_W-1:0]               headData,
  output trkStrobe_t                      stb,
  output logic [$clog2(WORDS)-1:0]        scanWord,
  output logic                            cpuReady,
  output logic                            overflow,
  output logic                            violation,
  output logic                            commitValid,
  output logic [ADDR_W-1:0]               commitAddr,
  output logic [DATA_W-1:0]               commitData,
  output logic                            commitDone
);

  localparam int WSEL_W = $clog2(WORDS);

  trkState_e state;
  logic idle, draining, newLineStore, accept, abortNow, writeThrough;

  assign idle         = (state == TRK_IDLE);
  assign draining     = (state == TRK_DRAIN);
  assign newLineStore = cpuValid && cpuWrite && !lineQueued && fifoFull;
  assign overflow     = idle && newLineStore;
  assign cpuReady     = idle && !(newLineStore && !tokenHeld);
  assign accept       = cpuValid && cpuReady;
  assign abortNow     = idle && snoopHit;
  assign writeThrough = accept && newLineStore;
  assign commitDone   = draining && fifoEmpty;

  always_comb begin
    stb           = '0;
    stb.setRead   = accept && !cpuWrite && !abortNow;
    stb.writeData = accept && cpuWrite && !abortNow;
    stb.setWrite  = stb.writeData && !newLineStore;
    stb.push      = stb.setWrite && !lineQueued;
    stb.pop       = draining && !fifoEmpty && (scanWord == WSEL_W'(WORDS - 1));
    stb.clearAll  = abortNow || commitDone;
  end

  assign commitValid = (draining && !fifoEmpty && headWritten) || writeThrough;
  assign commitAddr  = draining ? {headLine, scanWord} : cpuAddr;
  assign commitData  = draining ? headData : cpuWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= TRK_IDLE;
      scanWord  <= '0;
      violation <= 1'b0;
    end else begin
      violation <= abortNow;
      if (idle) begin
        scanWord <= '0;
        if (!abortNow && commitStart && tokenHeld) state <= TRK_DRAIN;
      end else if (fifoEmpty) begin
        state <= TRK_IDLE;
      end else begin
        scanWord <= (scanWord == WSEL_W'(WORDS - 1)) ? '0 : scanWord + WSEL_W'(1);
      end
    end
  end

endmodule

// File: rtl/trk_conflict_tracker.sv
module trk_conflict_tracker
  import trk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int WORDS      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              overflow,
  input  logic              tokenHeld,
  input  logic              commitStart,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              violation,
  output logic              commitValid,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData,
  output logic              commitDone
);

  localparam int WSEL_W = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - WSEL_W;

  trkStrobe_t        stb;
  logic [WSEL_W-1:0] scanWord;
  logic              snoopHit, lineQueued, fifoFull, fifoEmpty, headWritten;
  logic [LINE_W-1:0] headLine;
  logic [DATA_W-1:0] headData;

  trk_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .tokenHeld(tokenHeld),
    .commitStart(commitStart), .snoopHit(snoopHit), .lineQueued(lineQueued),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headLine(headLine),
    .headWritten(headWritten), .headData(headData), .stb(stb),
    .scanWord(scanWord), .cpuReady(cpuReady), .overflow(overflow),
    .violation(violation), .commitValid(commitValid), .commitAddr(commitAddr),
    .commitData(commitData), .commitDone(commitDone)
  );

  trk_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
                 .WORDS(WORDS), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .scanWord(scanWord),
    .snoopHit(snoopHit), .lineQueued(lineQueued), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .headLine(headLine), .headWritten(headWritten),
    .headData(headData)
  );

endmodule

// File: rtl/trk_conflict_checker.sv
module trk_conflict_checker (
  input logic clk,
  input logic rstN,
  input logic cpuValid,
  input logic tokenHeld,
  input logic snoopValid,
  input logic cpuReady,
  input logic overflow,
  input logic violation,
  input logic commitDone
);

  // R4: a violation lasts one cycle, because its own edge clears the read bits
  p_viol_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> !violation);

  // R4: a violation is always caused by a snoop in the previous cycle
  p_viol_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> $past(snoopValid));

  // R7: the done strobe is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);

  // R11: no access is accepted during the drain
  p_stall_drain_r11: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> !cpuReady);

  // R9: an overflowing store without permission is held off
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !tokenHeld) |-> !cpuReady);

  // R9: overflow only flags a presented access
  p_overflow_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> cpuValid);

endmodule

bind trk_conflict_tracker trk_conflict_checker u_chk (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .tokenHeld(tokenHeld),
  .snoopValid(snoopValid), .cpuReady(cpuReady), .overflow(overflow),
  .violation(violation), .commitDone(commitDone)
);

// File: tb/trk_conflict_tracker_test.sv
module trk_conflict_tracker_test;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NL = 16;
  localparam int NW = 8;
  localparam int FD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic tokenHeld = 1'b0, commitStart = 1'b0;
  logic snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;
  logic cpuReady, overflow, violation, commitValid, commitDone;
  logic [AW-1:0] commitAddr;
  logic [DW-1:0] commitData;

  always #5 clk = ~clk;

  trk_conflict_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW),
                         .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .overflow(overflow), .tokenHeld(tokenHeld), .commitStart(commitStart),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .violation(violation),
    .commitValid(commitValid), .commitAddr(commitAddr), .commitData(commitData),
    .commitDone(commitDone)
  );

  int checks = 0;
  int failures = 0;
  string scen = "R1";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", scen, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit            readSet  [int];
  bit            writeSet [int];
  logic [DW-1:0] mem      [int];
  int            lineQ    [$];
  bit            draining = 0;
  int            wc = 0;
  bit            violExp = 0;

  function automatic bit queued(input int ln);
    foreach (lineQ[i]) if (lineQ[i] == ln) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void clearModel();
    readSet.delete();
    writeSet.delete();
    lineQ.delete();
  endfunction

  always @(posedge clk) begin
    bit hit, inQ, newSt;
    int a, ln;
    if (!rstN) begin
      clearModel();
      draining = 0; wc = 0; violExp = 0;
    end else begin
      a  = int'(cpuAddr);
      ln = a / NW;
      hit = !draining && snoopValid && readSet.exists(int'(snoopAddr));
      violExp = hit;
      if (draining) begin
        if (lineQ.size() == 0) begin
          clearModel();
          draining = 0;
        end else if (wc == NW - 1) begin
          void'(lineQ.pop_front());
          wc = 0;
        end else wc++;
      end else if (hit) begin
        clearModel();
      end else begin
        inQ   = queued(ln);
        newSt = cpuValid && cpuWrite && !inQ && (lineQ.size() == FD);
        if (cpuValid && !(newSt && !tokenHeld)) begin
          if (!cpuWrite) readSet[a] = 1'b1;
          else begin
            mem[a] = cpuWdata;
            if (!newSt) begin
              writeSet[a] = 1'b1;
              if (!inQ) lineQ.push_back(ln);
            end
          end
        end
        if (commitStart && tokenHeld) begin
          draining = 1; wc = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    bit newSt, eReady, eOvf, eDone, eValid;
    int eAddr, eData, a;
    if (rstN) begin
      a      = int'(cpuAddr);
      newSt  = cpuValid && cpuWrite && !queued(a / NW) && (lineQ.size() == FD);
      eOvf   = !draining && newSt;
      eReady = !draining && !(newSt && !tokenHeld);
      eDone  = draining && (lineQ.size() == 0);
      eValid = 0; eAddr = 0; eData = 0;
      if (draining && lineQ.size() > 0) begin
        eAddr  = lineQ[0] * NW + wc;
        eValid = writeSet.exists(eAddr);
        if (eValid) eData = int'(mem[eAddr]);
      end else if (!draining && newSt && tokenHeld) begin
        eValid = 1; eAddr = a; eData = int'(cpuWdata);
      end
      chk(cpuReady == eReady, "R9/R11 cpuReady", int'(cpuReady), int'(eReady));
      chk(overflow == eOvf, "R9 overflow", int'(overflow), int'(eOvf));
      chk(violation == violExp, "R4 violation", int'(violation), int'(violExp));
      chk(commitDone == eDone, "R7 commitDone", int'(commitDone), int'(eDone));
      chk(commitValid == eValid, "R6 commitValid", int'(commitValid), int'(eValid));
      if (commitValid && eValid) begin
        chk(int'(commitAddr) == eAddr, "R6 commitAddr", int'(commitAddr), eAddr);
        chk(int'(commitData) == eData, "R6 commitData", int'(commitData), eData);
      end
    end
  end

  // Stimulus helpers: inputs change 1 ns after a rising edge
  task automatic step(input bit cv, input bit cw, input int ca, input int cd,
                      input bit sv, input int sa, input bit cs);
    @(posedge clk); #1;
    cpuValid = cv; cpuWrite = cw; cpuAddr = AW'(ca); cpuWdata = DW'(cd);
    snoopValid = sv; snoopAddr = AW'(sa); commitStart = cs;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic commitAll(input int lines);
    @(posedge clk); #1 tokenHeld = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1);
    idle(lines * NW + 2);
    @(posedge clk); #1 tokenHeld = 1'b0;
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!violation && !commitValid && !commitDone && !overflow && cpuReady,
        "R1 reset outputs", {violation, commitValid, commitDone, overflow, cpuReady}, 1);
    #1 rstN = 1'b1;
    idle(2);

    // R2: read bit is per word and tag-qualified
    scen = "R2";
    step(1, 0, 'h010, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 'h011, 0);
    step(0, 0, 0, 0, 1, 'h010 + NL * NW, 0);
    idle(2);

    // R3: written-only word is not a conflict
    scen = "R3";
    step(1, 1, 'h020, 'h1111, 0, 0, 0);
    step(0, 0, 0, 0, 1, 'h020, 0);
    idle(2);

    // R4: snoop hits a read word
    scen = "R4";
    step(0, 0, 0, 0, 1, 'h010, 0);
    idle(2);

    // R5: state was cleared by the violation
    scen = "R5";
    step(0, 0, 0, 0, 1, 'h010, 0);
    idle(1);
    commitAll(1);

    // R12: same-cycle load and snoop on one word
    scen = "R12";
    step(1, 0, 'h030, 0, 1, 'h030, 0);
    step(0, 0, 0, 0, 1, 'h030, 0);
    idle(2);

    // R6 / R8: ordered write set with a duplicate line, then drain
    scen = "R8";
    step(1, 0, 'h051, 0, 0, 0, 0);
    step(1, 1, 'h045, 'hA001, 0, 0, 0);
    step(1, 1, 'h021, 'hA002, 0, 0, 0);
    step(1, 1, 'h047, 'hA003, 0, 0, 0);
    step(1, 1, 'h045, 'hA004, 0, 0, 0);
    step(1, 1, 'h060, 'hA005, 0, 0, 0);
    scen = "R6";
    @(posedge clk); #1 tokenHeld = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1);
    // R11: snoop of a read word and a load during the drain
    scen = "R11";
    step(1, 0, 'h070, 0, 1, 'h051, 0);
    scen = "R6";
    idle(3 * NW + 2);
    @(posedge clk); #1 tokenHeld = 1'b0;

    // R7: nothing survives the commit
    scen = "R7";
    step(0, 0, 0, 0, 1, 'h051, 0);
    idle(2);

    // R9: fill the queue, then a new line stalls
    scen = "R9";
    step(1, 1, 'h100, 'hB000, 0, 0, 0);
    step(1, 1, 'h108, 'hB001, 0, 0, 0);
    step(1, 1, 'h110, 'hB002, 0, 0, 0);
    step(1, 1, 'h118, 'hB003, 0, 0, 0);
    step(1, 1, 'h120, 'hB004, 0, 0, 0);
    step(1, 1, 'h101, 'hB005, 0, 0, 0);
    idle(1);

    // R10: with permission the overflowing store is written through
    scen = "R10";
    @(posedge clk); #1 tokenHeld = 1'b1;
    step(1, 1, 'h128, 'hC00C, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(4 * NW + 2);
    @(posedge clk); #1 tokenHeld = 1'b0;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule